// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a small direct-mapped data cache placed between a CPU load/store port and a slower main memory. Loads that hit return their word on the next cycle. Loads that miss fetch the whole line from memory, one word per memory transaction, and then complete as hits. Every store is passed on to memory. It is first put into a shallow first-in first-out queue of posted writes, so the CPU moves on at once and does not wait for the memory latency. A store that hits also updates the cached word. A store that misses goes only to the queue and never allocates a line.

The queue drains into memory on its own, one entry per memory acknowledge. The CPU stalls on a store only while the queue is full. A load miss must not fetch a line while an older store to it is still waiting in the queue. By default the fetch waits until the queue is empty. An option lets it wait only while a queued store targets the same line. The CPU port is a valid/stall pair: a request is taken on a rising edge where `cpu_valid` is high and `cpu_stall` is low, and the CPU holds its request until then. The memory port is a request/acknowledge pair with any latency.

Top module: `wt_post_cache`

## Requirements
- R1: After reset every line is invalid. With `cpu_valid` low, `cpu_stall`, `cpu_rvalid` and `mem_req` are all low.
- R2: A load that misses is stalled while the line is fetched with LINE_WORDS memory reads (LINE_WORDS = 2 by default). It then completes with the word from memory.
- R3: A load that hits is taken with no stall. `cpu_rvalid` is high with the cached word in the cycle after it is taken, and no memory read is issued. This also holds while the queue is draining.
- R4: A store is taken in the cycle it is presented when the queue has a free entry (WB_DEPTH = 4 by default).
- R5: A store that hits updates the cached word, and a later load returns the new value. `cpu_be` bit b selects byte bits 8b+7..8b.
- R6: Every store taken is written to memory. Once the queue is empty, memory and every cached word equal the reference memory.
- R7: A store that misses allocates no line, so a later load to that address misses.
- R8: Queued stores reach memory in the order they were taken. A memory request holds its address, data and direction stable until `mem_ack`, which is a one-cycle pulse. When two stores go to one address, the later value remains in memory.
- R9: A store presented while all WB_DEPTH entries are occupied is stalled until an entry drains.
- R10: In the default mode (DRAIN_ALL = 1), no line-fetch read is issued while any store taken earlier is still unwritten. A load that misses right after a store to that address returns the stored value.
- R11: Memory writes carry the byte mask, so memory bytes whose `cpu_be` bit is clear keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_stall | output | 1 | Request not taken this cycle |
| cpu_rvalid | output | 1 | Load data valid (cycle after take) |
| cpu_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory write byte mask |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
A request is taken on the first rising edge at which `cpu_stall` is low. The bench drives each request just after a falling edge and tests `cpu_stall` one time step later. It samples `cpu_rvalid` and `cpu_rdata` at the next falling edge, which is half a cycle after the register that holds the load result is loaded. Stalls are counted in whole cycles, so a zero count means the request was taken in its first cycle and a nonzero count means a fetch or a full queue held it. Memory results fall due only after the queue has drained. The bench's memory model counts acknowledged writes against stores taken and waits until the two counts match before it compares memory contents or write order. It also records any read that starts while the counts differ.

// File: rtl/wtpc_pkg.sv
package wtpc_pkg;
   typedef enum logic [1:0] {
      CT_IDLE  = 2'd0,
      CT_WAIT  = 2'd1,
      CT_FETCH = 2'd2
   } ctl_state_e;
endpackage

// File: rtl/wtpc_array.sv
module wtpc_array #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int LINES      = 8,
   parameter int LINE_WORDS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   lk_addr,
   output logic                hit,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic                fill_en,
   input  logic [ADDR_W-1:0]   fill_addr,
   input  logic [DATA_W-1:0]   fill_data,
   input  logic                fill_first,
   input  logic                fill_last
);
   localparam int BE_W  = DATA_W / 8;
   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam int WRD_W = IDX_W + OFF_W;
   localparam int WORDS = LINES * LINE_WORDS;

   logic [DATA_W-1:0] data_q [WORDS];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINES-1:0]  vld_q;

   logic [IDX_W-1:0] lk_idx, f_idx;
   logic [TAG_W-1:0] lk_tag, f_tag;
   logic [WRD_W-1:0] lk_wrd, f_wrd;

   assign lk_idx = lk_addr[OFF_W +: IDX_W];
   assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
   assign lk_wrd = lk_addr[WRD_W-1:0];
   assign f_idx  = fill_addr[OFF_W +: IDX_W];
   assign f_tag  = fill_addr[ADDR_W-1 -: TAG_W];
   assign f_wrd  = fill_addr[WRD_W-1:0];

   assign hit     = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign rd_data = data_q[lk_wrd];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (fill_en && fill_last) begin
         vld_q[f_idx] <= 1'b1;
      end else if (fill_en && fill_first) begin
         vld_q[f_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && fill_last) begin
         tag_q[f_idx] <= f_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         data_q[f_wrd] <= fill_data;
      end else if (wr_en) begin
         for (int b = 0; b < BE_W; b++) begin
            if (wr_be[b]) begin
               data_q[lk_wrd][8*b +: 8] <= wr_data[8*b +: 8];
            end
         end
      end
   end
endmodule

// File: rtl/wtpc_wbuf.sv
module wtpc_wbuf #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   parameter int OFF_W  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic [ADDR_W-1:0]    push_addr,
   input  logic [DATA_W-1:0]    push_data,
   input  logic [DATA_W/8-1:0]  push_be,
   input  logic                 pop,
   input  logic [ADDR_W-OFF_W-1:0] probe_line,
   output logic [ADDR_W-1:0]    head_addr,
   output logic [DATA_W-1:0]    head_data,
   output logic [DATA_W/8-1:0]  head_be,
   output logic                 empty,
   output logic                 full,
   output logic                 match
);
   localparam int BE_W  = DATA_W / 8;
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   logic [BE_W-1:0]   e_be   [DEPTH];
   logic [DEPTH-1:0]  e_vld;
   logic [DEPTH-1:0]  e_hit;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty     = (count == '0);
   assign full      = (count == CNT_W'(DEPTH));
   assign head_addr = e_addr[rd_ptr];
   assign head_data = e_data[rd_ptr];
   assign head_be   = e_be[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_probe
      assign e_hit[i] = e_vld[i] && (e_addr[i][ADDR_W-1:OFF_W] == probe_line);
   end
   assign match = |e_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         e_vld  <= '0;
      end else begin
         if (push) begin
            wr_ptr        <= nxt(wr_ptr);
            e_vld[wr_ptr] <= 1'b1;
         end
         if (pop) begin
            rd_ptr <= nxt(rd_ptr);
            if (!(push && (wr_ptr == rd_ptr))) begin
               e_vld[rd_ptr] <= 1'b0;
            end
         end
         if (push && !pop) begin
            count <= count + 1'b1;
         end else if (pop && !push) begin
            count <= count - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         e_addr[wr_ptr] <= push_addr;
         e_data[wr_ptr] <= push_data;
         e_be[wr_ptr]   <= push_be;
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/wtpc_ctrl.sv
module wtpc_ctrl
   import wtpc_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int LINE_WORDS = 2,
   parameter bit DRAIN_ALL  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_valid,
   input  logic                      cpu_we,
   input  logic [ADDR_W-1:0]         cpu_addr,
   input  logic                      hit,
   input  logic                      wb_full,
   input  logic                      wb_empty,
   input  logic                      wb_match,
   input  logic                      wr_pop,
   input  logic                      mem_ack,
   output logic                      cpu_stall,
   output logic                      ld_accept,
   output logic                      st_accept,
   output logic                      rd_req,
   output logic [ADDR_W-1:0]         rd_addr,
   output logic                      fill_en,
   output logic                      fill_first,
   output logic                      fill_last,
   output logic                      drain_en,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] miss_line
);
   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int LN_W  = ADDR_W - OFF_W;

   ctl_state_e       state;
   logic [LN_W-1:0]  line_q;
   logic [OFF_W-1:0] fcnt;
   logic             no_conflict;
   logic             go_fetch;
   logic             ld_miss;

   if (DRAIN_ALL) begin : g_all
      assign no_conflict = wb_empty & ~wb_match;
   end else begin : g_line
      assign no_conflict = ~wb_match;
   end

   assign ld_miss    = cpu_valid & ~cpu_we & ~hit;
   assign cpu_stall  = cpu_valid & ((state != CT_IDLE) | (~cpu_we & ~hit) | (cpu_we & wb_full));
   assign ld_accept  = cpu_valid & ~cpu_we & ~cpu_stall;
   assign st_accept  = cpu_valid &  cpu_we & ~cpu_stall;
   assign go_fetch   = (state == CT_WAIT) & no_conflict & (wb_empty | wr_pop);
   assign rd_req     = (state == CT_FETCH);
   assign rd_addr    = {line_q, fcnt};
   assign fill_en    = rd_req & mem_ack;
   assign fill_first = (fcnt == '0);
   assign fill_last  = &fcnt;
   assign drain_en   = (state != CT_FETCH);
   assign miss_line  = line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= CT_IDLE;
         line_q <= '0;
         fcnt   <= '0;
      end else begin
         case (state)
            CT_IDLE: begin
               if (ld_miss) begin
                  state  <= CT_WAIT;
                  line_q <= cpu_addr[ADDR_W-1:OFF_W];
               end
            end
            CT_WAIT: begin
               if (go_fetch) begin
                  state <= CT_FETCH;
                  fcnt  <= '0;
               end
            end
            CT_FETCH: begin
               if (mem_ack) begin
                  fcnt <= fcnt + 1'b1;
                  if (fill_last) begin
                     state <= CT_IDLE;
                  end
               end
            end
            default: state <= CT_IDLE;
         endcase
      end
   end

   // R10
   fetch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !wb_match);

   if (DRAIN_ALL) begin : g_all_chk
      // R10
      fetch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_req |-> wb_empty);
   end
endmodule

// File: rtl/wt_post_cache.sv
module wt_post_cache #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int LINES      = 8,
   parameter int LINE_WORDS = 2,
   parameter int WB_DEPTH   = 4,
   parameter bit DRAIN_ALL  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_valid,
   input  logic                cpu_we,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic [DATA_W/8-1:0] cpu_be,
   output logic                cpu_stall,
   output logic                cpu_rvalid,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [DATA_W/8-1:0] mem_be,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata
);
   localparam int BE_W  = DATA_W / 8;
   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W = $clog2(LINES);
   localparam int LN_W  = ADDR_W - OFF_W;

   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (WB_DEPTH < 2) begin : g_bad_depth
      $error("WB_DEPTH must be at least 2");
   end
   if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic              hit;
   logic [DATA_W-1:0] arr_rdata;
   logic              ld_accept, st_accept;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              fill_en, fill_first, fill_last;
   logic              drain_en;
   logic [LN_W-1:0]   miss_line;
   logic              wb_empty, wb_full, wb_match;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data;
   logic [BE_W-1:0]   head_be;
   logic              head_vld;
   logic              wr_pop;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   wtpc_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_addr    (cpu_addr),
      .hit        (hit),
      .rd_data    (arr_rdata),
      .wr_en      (st_accept & hit),
      .wr_data    (cpu_wdata),
      .wr_be      (cpu_be),
      .fill_en    (fill_en),
      .fill_addr  (rd_addr),
      .fill_data  (mem_rdata),
      .fill_first (fill_first),
      .fill_last  (fill_last)
   );

   wtpc_wbuf #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH), .OFF_W(OFF_W)
   ) u_wbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (st_accept),
      .push_addr  (cpu_addr),
      .push_data  (cpu_wdata),
      .push_be    (cpu_be),
      .pop        (wr_pop),
      .probe_line (miss_line),
      .head_addr  (head_addr),
      .head_data  (head_data),
      .head_be    (head_be),
      .empty      (wb_empty),
      .full       (wb_full),
      .match      (wb_match)
   );

   wtpc_ctrl #(
      .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .DRAIN_ALL(DRAIN_ALL)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_valid  (cpu_valid),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .hit        (hit),
      .wb_full    (wb_full),
      .wb_empty   (wb_empty),
      .wb_match   (wb_match),
      .wr_pop     (wr_pop),
      .mem_ack    (mem_ack),
      .cpu_stall  (cpu_stall),
      .ld_accept  (ld_accept),
      .st_accept  (st_accept),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .fill_en    (fill_en),
      .fill_first (fill_first),
      .fill_last  (fill_last),
      .drain_en   (drain_en),
      .miss_line  (miss_line)
   );

   assign head_vld  = ~wb_empty & drain_en;
   assign wr_pop    = mem_ack & head_vld & ~rd_req;
   assign mem_req   = rd_req | head_vld;
   assign mem_we    = ~rd_req;
   assign mem_addr  = rd_req ? rd_addr : head_addr;
   assign mem_wdata = head_data;
   assign mem_be    = rd_req ? {BE_W{1'b1}} : head_be;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= ld_accept;
      end
   end

   always_ff @(posedge clk) begin
      if (ld_accept) begin
         rdata_q <= arr_rdata;
      end
   end

   assign cpu_rvalid = rvalid_q;
   assign cpu_rdata  = rdata_q;

   // R6
   push_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_accept |=> !wb_empty);
   // R8
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && (mem_we -> $stable(mem_wdata))));
endmodule

// File: tb/wt_post_cache_tb.sv
module wt_post_cache_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int NW = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_we = 1'b0;
   logic [9:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic        cpu_stall, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [9:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wt_post_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model
   logic [31:0] mem_model [NW];
   logic [31:0] ref_mem   [NW];
   logic [9:0]  wlog [64];
   int lat = 2;
   int cnt = 0;
   int writes_done = 0;
   int reads_n = 0;
   int rd_viol = 0;
   int wlog_n = 0;
   int stores_acc = 0;
   logic ack_q = 1'b0;
   logic [31:0] rdata_q = '0;
   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;

   function automatic logic [31:0] init_word(input int a);
      return 32'hC0DE0000 | 32'(a);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         cnt   <= 0;
         for (int i = 0; i < NW; i++) mem_model[i] <= init_word(i);
      end else if (ack_q) begin
         ack_q <= 1'b0;
         cnt   <= 0;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            ack_q <= 1'b1;
            if (mem_we) begin
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) mem_model[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
               wlog[wlog_n % 64] <= mem_addr;
               wlog_n      <= wlog_n + 1;
               writes_done <= writes_done + 1;
            end else begin
               rdata_q <= mem_model[mem_addr];
               reads_n <= reads_n + 1;
               if (writes_done != stores_acc) rd_viol <= rd_viol + 1;
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic cpu_op(input bit st, input logic [9:0] a, input logic [31:0] d,
                         input logic [3:0] be, output int stalls, output logic [31:0] rd,
                         output bit rv);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = st; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      stalls = 0;
      #1;
      while (cpu_stall) begin
         @(negedge clk);
         #1;
         stalls++;
      end
      if (st) begin
         for (int b = 0; b < 4; b++)
            if (be[b]) ref_mem[a][8*b +: 8] = d[8*b +: 8];
         stores_acc++;
      end
      @(negedge clk);
      rv = cpu_rvalid;
      rd = cpu_rdata;
      cpu_valid = 1'b0;
      cpu_we = 1'b0;
   endtask

   task automatic wait_drain();
      while (writes_done != stores_acc) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   typedef struct packed {
      logic        st;
      logic [9:0]  addr;
      logic [31:0] wd;
      logic [3:0]  be;
      logic [31:0] exp;
      logic        miss;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 10'h004, 32'h0,        4'h0, 32'hC0DE0004, 1'b1, 4'd2},  // R2 cold miss
      '{1'b0, 10'h005, 32'h0,        4'h0, 32'hC0DE0005, 1'b0, 4'd3},  // R3 hit same line
      '{1'b1, 10'h004, 32'h11223344, 4'hF, 32'h0,        1'b0, 4'd4},  // R4 store hit
      '{1'b0, 10'h004, 32'h0,        4'h0, 32'h11223344, 1'b0, 4'd5},  // R5 updated word
      '{1'b1, 10'h005, 32'hAABBCCDD, 4'h3, 32'h0,        1'b0, 4'd4},  // R4 partial store
      '{1'b0, 10'h005, 32'h0,        4'h0, 32'hC0DECCDD, 1'b0, 4'd5},  // R5 byte merge
      '{1'b1, 10'h020, 32'h55667788, 4'hF, 32'h0,        1'b0, 4'd4},  // R4 store miss
      '{1'b0, 10'h020, 32'h0,        4'h0, 32'h55667788, 1'b1, 4'd7},  // R7 R10 no alloc
      '{1'b0, 10'h014, 32'h0,        4'h0, 32'hC0DE0014, 1'b1, 4'd2},  // R2 conflict evict
      '{1'b0, 10'h004, 32'h0,        4'h0, 32'h11223344, 1'b1, 4'd6},  // R6 refetch
      '{1'b1, 10'h021, 32'h0F0F0F0F, 4'h8, 32'h0,        1'b0, 4'd4},  // R4 byte3 store
      '{1'b0, 10'h021, 32'h0,        4'h0, 32'h0FDE0021, 1'b0, 4'd5}   // R5 byte3 merge
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      int st_n;
      logic [31:0] rd;
      bit rv;
      int mism;
      int r0;
      string tag;

      for (int i = 0; i < NW; i++) ref_mem[i] = init_word(i);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cpu_stall == 1'b0, "R1 stall", 32'(cpu_stall), 32'h0);
      chk(cpu_rvalid == 1'b0, "R1 rvalid", 32'(cpu_rvalid), 32'h0);
      chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req == 1'b0 && cpu_stall == 1'b0, "R1 idle", 32'({mem_req, cpu_stall}), 32'h0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         tag = $sformatf("R%0d row %0d", TBL[v].req, v);
         cpu_op(TBL[v].st, TBL[v].addr, TBL[v].wd, TBL[v].be, st_n, rd, rv);
         if (TBL[v].st) begin
            chk(st_n == 0, tag, 32'(st_n), 32'h0);
         end else begin
            chk(rv == 1'b1, {tag, " rvalid"}, 32'(rv), 32'h1);
            chk(rd == TBL[v].exp, {tag, " data"}, rd, TBL[v].exp);
            chk((st_n > 0) == TBL[v].miss, {tag, " stall"}, 32'(st_n), 32'(TBL[v].miss));
         end
      end

      // R6 memory equals reference after drain; R11 masked bytes
      wait_drain();
      mism = 0;
      for (int i = 0; i < NW; i++) if (mem_model[i] !== ref_mem[i]) mism++;
      chk(mism == 0, "R6 memory mismatches", 32'(mism), 32'h0);
      chk(mem_model[10'h005] == 32'hC0DECCDD, "R11 byte mask", mem_model[10'h005], 32'hC0DECCDD);
      chk(mem_model[10'h021] == 32'h0FDE0021, "R11 byte3 mask", mem_model[10'h021], 32'h0FDE0021);

      // R9 full queue stalls; R4 free entries take stores at once
      lat = 20;
      for (int k = 0; k < 4; k++) begin
         cpu_op(1'b1, 10'h100 + 10'(k), 32'h00AB0000 + 32'(k), 4'hF, st_n, rd, rv);
         chk(st_n == 0, "R4 store with free entry", 32'(st_n), 32'h0);
      end
      cpu_op(1'b1, 10'h104, 32'h00AB0004, 4'hF, st_n, rd, rv);
      chk(st_n > 0, "R9 store stalls when full", 32'(st_n), 32'h1);

      // R3 hit while draining
      r0 = reads_n;
      cpu_op(1'b0, 10'h004, 32'h0, 4'h0, st_n, rd, rv);
      chk(st_n == 0, "R3 hit no stall while draining", 32'(st_n), 32'h0);
      chk(rv && rd == 32'h11223344, "R3 hit data while draining", rd, 32'h11223344);
      chk(reads_n == r0, "R3 no memory read", 32'(reads_n - r0), 32'h0);

      // R8 write order
      wait_drain();
      for (int k = 0; k < 5; k++) begin
         chk(wlog[(wlog_n - 5 + k) % 64] == 10'h100 + 10'(k), "R8 order",
             32'(wlog[(wlog_n - 5 + k) % 64]), 32'h100 + 32'(k));
      end
      lat = 5;
      cpu_op(1'b1, 10'h200, 32'h11111111, 4'hF, st_n, rd, rv);
      cpu_op(1'b1, 10'h200, 32'h22222222, 4'hF, st_n, rd, rv);
      wait_drain();
      chk(mem_model[10'h200] == 32'h22222222, "R8 later value wins", mem_model[10'h200], 32'h22222222);

      // R10 load miss right after queued store
      lat = 15;
      cpu_op(1'b1, 10'h300, 32'hDEADBEEF, 4'hF, st_n, rd, rv);
      cpu_op(1'b0, 10'h300, 32'h0, 4'h0, st_n, rd, rv);
      chk(rd == 32'hDEADBEEF, "R10 fetch after drain", rd, 32'hDEADBEEF);
      chk(st_n > 0, "R7 store miss left line unallocated", 32'(st_n), 32'h1);

      // R2 miss reads both words
      lat = 3;
      r0 = reads_n;
      cpu_op(1'b0, 10'h041, 32'h0, 4'h0, st_n, rd, rv);
      chk(reads_n - r0 == 2, "R2 line fill read count", 32'(reads_n - r0), 32'h2);
      chk(rd == 32'hC0DE0041, "R2 fill data", rd, 32'hC0DE0041);

      // R6 cached words equal reference
      wait_drain();
      cpu_op(1'b0, 10'h004, 32'h0, 4'h0, st_n, rd, rv);
      chk(rd == ref_mem[10'h004], "R6 cached word", rd, ref_mem[10'h004]);
      cpu_op(1'b0, 10'h005, 32'h0, 4'h0, st_n, rd, rv);
      chk(rd == ref_mem[10'h005], "R6 cached word", rd, ref_mem[10'h005]);
      cpu_op(1'b0, 10'h300, 32'h0, 4'h0, st_n, rd, rv);
      chk(rd == ref_mem[10'h300], "R6 cached word", rd, ref_mem[10'h300]);
      chk(rd_viol == 0, "R10 reads while stores pending", 32'(rd_viol), 32'h0);

      summary();
      $finish;
   end
endmodule